// File: doc/BRIEF.md
# Lockstep Shared Memory with Selectable Collision Policy

This block is a small word-addressed memory shared by a fixed number of processor ports that all advance together on one clock. Every clock edge is one step: each port may issue a read and a write for one address, reads see the contents as they were before the step, and all writes of the step land together at the edge. Nothing else in the block takes time. Read data comes back on the port's data output one cycle after the step.

Two mode inputs choose whether a single address may be read by several ports in one step, and whether it may be written by several ports in one step. When several writes to one address are allowed, a policy input chooses how they merge. The four choices are: all writers must agree, a rotating pointer picks one writer, the values are added, or the lowest-numbered port wins. A forbidden access raises a one-cycle error pulse, one cycle after the offending step.

Top module: `pram_arbiter_mem`

## Requirements
- R1: After reset every memory word reads as zero, every read data output is zero, the error output is low, and the rotating pointer is at port 0.
- R2: A port with its read request set gets, one cycle after the step, the word its address held before any write of that same step; a port without a read request keeps its previous read data.
- R3: With `rd_conc` low, two or more ports reading one address in a step raise `err` in the following cycle; the read data is still returned.
- R4: With `wr_conc` low, two or more ports writing one address in a step raise `err` in the following cycle and leave that word unchanged, while single writes to other addresses in the same step are still stored.
- R5: With `wr_conc` high and `wr_policy` = 0 (agree), colliding writers that all present the same value store it; if any value differs, the word keeps its old contents and `err` pulses for one cycle.
- R6: With `wr_conc` high and `wr_policy` = 1 (rotate), the pointer advances by one modulo the port count on every clock after reset, and a collision stores the value of the first colliding port found when scanning upward from the pointer, wrapping around.
- R7: With `wr_conc` high and `wr_policy` = 2 (add), a collision stores the sum of all colliding values modulo 2^DATA_W.
- R8: With `wr_conc` high and `wr_policy` = 3 (rank), a collision stores the value of the lowest-numbered colliding port.
- R9: A write from a single port to an address is stored under every mode and policy, and `err` stays low in any step without a forbidden access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_conc | input | 1 | 1: several readers of one address allowed |
| wr_conc | input | 1 | 1: several writers of one address allowed |
| wr_policy | input | 2 | Collision merge: 0 agree, 1 rotate, 2 add, 3 rank |
| rd_req | input | N_PORTS | Read request per port |
| wr_req | input | N_PORTS | Write request per port |
| addr | input | N_PORTS*ADDR_W | Address per port, port i at bits i*ADDR_W |
| wdata | input | N_PORTS*DATA_W | Write value per port, port i at bits i*DATA_W |
| rdata | output | N_PORTS*DATA_W | Registered read data per port |
| err | output | 1 | One-cycle pulse after a forbidden access |

## Verification
On every cycle the checker recomputes the same-address pairs of readers and writers from the ports and confirms that forbidden pairs in an exclusive mode raise the error pulse, that steps with no shared address never do, that non-agree merge policies with both concurrent modes never do, and that the rotating pointer steps by one. The stored values under each merge policy, the pre-write read semantics and the hold of read data on idle ports are only visible through the bench's reference model, which replays every step and compares all read outputs and the error pulse each cycle across directed collisions, additive overflow, pointer wrap-around and a long random stretch on a narrow address range.

// File: rtl/pram_pkg.sv
package pram_pkg;
    typedef enum logic [1:0] {
        POL_AGREE  = 2'd0,
        POL_ROTATE = 2'd1,
        POL_ADD    = 2'd2,
        POL_RANK   = 2'd3
    } wpol_e;
endpackage

// File: rtl/pram_conflict.sv
module pram_conflict #(
    parameter int N_PORTS = 4,
    parameter int ADDR_W  = 4
) (
    input  logic [N_PORTS-1:0]        rd_req,
    input  logic [N_PORTS-1:0]        wr_req,
    input  logic [N_PORTS*ADDR_W-1:0] addr,
    output logic                      rd_clash,
    output logic                      wr_clash
);
    always_comb begin
        rd_clash = 1'b0;
        wr_clash = 1'b0;
        for (int i = 0; i < N_PORTS; i++) begin
            for (int j = i + 1; j < N_PORTS; j++) begin
                if (addr[i*ADDR_W +: ADDR_W] == addr[j*ADDR_W +: ADDR_W]) begin
                    if (rd_req[i] && rd_req[j]) rd_clash = 1'b1;
                    if (wr_req[i] && wr_req[j]) wr_clash = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pram_cell_resolve.sv
module pram_cell_resolve
    import pram_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int DATA_W  = 8,
    parameter int PTR_W   = 2
) (
    input  logic [N_PORTS-1:0]        hit,
    input  logic [N_PORTS*DATA_W-1:0] wdata,
    input  logic                      conc_wr,
    input  wpol_e                     policy,
    input  logic [PTR_W-1:0]          rr,
    output logic                      we,
    output logic [DATA_W-1:0]         val,
    output logic                      mismatch
);
    logic [DATA_W-1:0] low_val;
    logic [DATA_W-1:0] rot_val;
    logic [DATA_W-1:0] sum_val;
    logic              all_eq;
    logic              rot_found;
    int                n_hit;

    always_comb begin
        n_hit   = $countones(hit);
        low_val = '0;
        for (int i = N_PORTS - 1; i >= 0; i--) begin
            if (hit[i]) low_val = wdata[i*DATA_W +: DATA_W];
        end
        all_eq  = 1'b1;
        sum_val = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (hit[i]) begin
                sum_val = sum_val + wdata[i*DATA_W +: DATA_W];
                if (wdata[i*DATA_W +: DATA_W] != low_val) all_eq = 1'b0;
            end
        end
        rot_found = 1'b0;
        rot_val   = '0;
        for (int k = 0; k < N_PORTS; k++) begin
            int idx;
            idx = (int'(rr) + k) % N_PORTS;
            if (!rot_found && hit[idx]) begin
                rot_found = 1'b1;
                rot_val   = wdata[idx*DATA_W +: DATA_W];
            end
        end
        unique case (policy)
            POL_ROTATE: val = rot_val;
            POL_ADD:    val = sum_val;
            default:    val = low_val;
        endcase
        mismatch = conc_wr && (policy == POL_AGREE) && (n_hit > 1) && !all_eq;
        we       = (n_hit == 1) || ((n_hit > 1) && conc_wr && !mismatch);
    end
endmodule

// File: rtl/pram_arbiter_mem.sv
module pram_arbiter_mem
    import pram_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_conc,
    input  logic                      wr_conc,
    input  logic [1:0]                wr_policy,
    input  logic [N_PORTS-1:0]        rd_req,
    input  logic [N_PORTS-1:0]        wr_req,
    input  logic [N_PORTS*ADDR_W-1:0] addr,
    input  logic [N_PORTS*DATA_W-1:0] wdata,
    output logic [N_PORTS*DATA_W-1:0] rdata,
    output logic                      err
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PTR_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             rr;
        logic [N_PORTS*DATA_W-1:0]    rdata;
        logic                         err;
    } state_t;

    state_t s_d, s_q;

    logic                          rd_clash, wr_clash;
    logic [DEPTH-1:0]              cell_we;
    logic [DEPTH-1:0]              cell_bad;
    logic [DEPTH-1:0][DATA_W-1:0]  cell_val;
    logic [PTR_W-1:0]              rr_ptr;
    wpol_e                         pol;

    assign pol    = wpol_e'(wr_policy);
    assign rr_ptr = s_q.rr;

    pram_conflict #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_conflict (
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .addr     (addr),
        .rd_clash (rd_clash),
        .wr_clash (wr_clash)
    );

    for (genvar w = 0; w < DEPTH; w++) begin : g_cell
        logic [N_PORTS-1:0] hit;
        always_comb begin
            for (int i = 0; i < N_PORTS; i++) begin
                hit[i] = wr_req[i] && (addr[i*ADDR_W +: ADDR_W] == ADDR_W'(w));
            end
        end
        pram_cell_resolve #(.N_PORTS(N_PORTS), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_res (
            .hit      (hit),
            .wdata    (wdata),
            .conc_wr  (wr_conc),
            .policy   (pol),
            .rr       (s_q.rr),
            .we       (cell_we[w]),
            .val      (cell_val[w]),
            .mismatch (cell_bad[w])
        );
    end

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < N_PORTS; i++) begin
            if (rd_req[i]) begin
                s_d.rdata[i*DATA_W +: DATA_W] = s_q.mem[addr[i*ADDR_W +: ADDR_W]];
            end
        end
        for (int w = 0; w < DEPTH; w++) begin
            if (cell_we[w]) s_d.mem[w] = cell_val[w];
        end
        s_d.rr  = (s_q.rr == PTR_W'(N_PORTS - 1)) ? '0 : s_q.rr + 1'b1;
        s_d.err = (!rd_conc && rd_clash) || (!wr_conc && wr_clash) || (|cell_bad);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.rdata;
    assign err   = s_q.err;
endmodule

// File: rtl/pram_sva.sv
module pram_sva #(
    parameter int N_PORTS = 4,
    parameter int ADDR_W  = 4,
    parameter int PTR_W   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      rd_conc,
    input logic                      wr_conc,
    input logic [1:0]                wr_policy,
    input logic [N_PORTS-1:0]        rd_req,
    input logic [N_PORTS-1:0]        wr_req,
    input logic [N_PORTS*ADDR_W-1:0] addr,
    input logic                      err,
    input logic [PTR_W-1:0]          rr_ptr
);
    logic rd_pair, wr_pair;

    always_comb begin
        rd_pair = 1'b0;
        wr_pair = 1'b0;
        for (int a = 0; a < N_PORTS; a++) begin
            for (int b = 0; b < N_PORTS; b++) begin
                if (a != b && addr[a*ADDR_W +: ADDR_W] == addr[b*ADDR_W +: ADDR_W]) begin
                    rd_pair = rd_pair | (rd_req[a] & rd_req[b]);
                    wr_pair = wr_pair | (wr_req[a] & wr_req[b]);
                end
            end
        end
    end

    assert_excl_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_conc && rd_pair) |=> err);

    assert_excl_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_conc && wr_pair) |=> err);

    assert_quiet_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_pair && !wr_pair) |=> !err);

    assert_merge_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_conc && wr_conc && wr_policy != 2'd0) |=> !err);

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(rr_ptr) == (int'($past(rr_ptr)) + 1) % N_PORTS));
endmodule

bind pram_arbiter_mem pram_sva #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_conc   (rd_conc),
    .wr_conc   (wr_conc),
    .wr_policy (wr_policy),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .addr      (addr),
    .err       (err),
    .rr_ptr    (rr_ptr)
);

// File: tb/pram_arbiter_mem_tb.sv
module pram_arbiter_mem_tb;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rdc = 1'b1, wrc = 1'b1;
    logic [1:0]        pol = 2'd0;
    logic [N-1:0]      rd = '0, wr = '0;
    logic [AW-1:0]     ad [N];
    logic [DW-1:0]     wd [N];
    logic [N*AW-1:0]   addr_f;
    logic [N*DW-1:0]   wdata_f, rdata_f;
    logic              err;

    logic [DW-1:0]     mem_m [DEPTH];
    logic [DW-1:0]     exp_rd [N];
    logic              exp_err;
    int                rr_m;
    int                checks = 0, errors = 0;
    string             cur_req = "R1";
    bit                done = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            addr_f[i*AW +: AW]  = ad[i];
            wdata_f[i*DW +: DW] = wd[i];
        end
    end

    pram_arbiter_mem #(.N_PORTS(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_conc(rdc), .wr_conc(wrc), .wr_policy(pol),
        .rd_req(rd), .wr_req(wr), .addr(addr_f), .wdata(wdata_f),
        .rdata(rdata_f), .err(err)
    );

    task automatic compare();
        for (int i = 0; i < N; i++) begin
            checks++;
            if (rdata_f[i*DW +: DW] !== exp_rd[i]) begin
                errors++;
                $display("FAIL %s port %0d rdata actual=%0h expected=%0h", cur_req, i,
                         rdata_f[i*DW +: DW], exp_rd[i]);
            end
        end
        checks++;
        if (err !== exp_err) begin
            errors++;
            $display("FAIL %s err actual=%0b expected=%0b", cur_req, err, exp_err);
        end
    endtask

    task automatic idle();
        rd = '0; wr = '0;
        for (int i = 0; i < N; i++) begin ad[i] = '0; wd[i] = '0; end
    endtask

    task automatic do_step();
        logic [DW-1:0] nmem [DEPTH];
        bit e;
        e = 0;
        nmem = mem_m;
        for (int a = 0; a < DEPTH; a++) begin
            int rc;
            rc = 0;
            for (int i = 0; i < N; i++) if (rd[i] && ad[i] == AW'(a)) rc++;
            if (!rdc && rc > 1) e = 1;
        end
        for (int i = 0; i < N; i++) if (rd[i]) exp_rd[i] = mem_m[ad[i]];
        for (int a = 0; a < DEPTH; a++) begin
            int wq[$];
            for (int i = 0; i < N; i++) if (wr[i] && ad[i] == AW'(a)) wq.push_back(i);
            if (wq.size() == 1) nmem[a] = wd[wq[0]];
            else if (wq.size() > 1) begin
                if (!wrc) e = 1;
                else begin
                    case (pol)
                        2'd0: begin
                            bit same;
                            same = 1;
                            foreach (wq[k]) if (wd[wq[k]] != wd[wq[0]]) same = 0;
                            if (same) nmem[a] = wd[wq[0]]; else e = 1;
                        end
                        2'd1: begin
                            int win;
                            win = -1;
                            for (int k = 0; k < N; k++) begin
                                int idx;
                                idx = (rr_m + k) % N;
                                if (win < 0 && wr[idx] && ad[idx] == AW'(a)) win = idx;
                            end
                            nmem[a] = wd[win];
                        end
                        2'd2: begin
                            logic [DW-1:0] s;
                            s = '0;
                            foreach (wq[k]) s = s + wd[wq[k]];
                            nmem[a] = s;
                        end
                        default: nmem[a] = wd[wq[0]];
                    endcase
                end
            end
        end
        exp_err = e;
        @(posedge clk);
        mem_m = nmem;
        rr_m = (rr_m + 1) % N;
        @(negedge clk);
        compare();
    endtask

    task automatic read_all(input string tag);
        cur_req = tag;
        rdc = 1'b1;
        for (int b = 0; b < DEPTH; b += N) begin
            idle();
            for (int i = 0; i < N; i++) begin rd[i] = 1'b1; ad[i] = AW'(b + i); end
            do_step();
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        idle();
        for (int a = 0; a < DEPTH; a++) mem_m[a] = '0;
        for (int i = 0; i < N; i++) exp_rd[i] = '0;
        exp_err = 0;
        rr_m = 0;
        repeat (3) @(negedge clk);
        // R1: reset outputs
        cur_req = "R1";
        compare();
        rst_n = 1'b1;
        read_all("R1");

        // R9: single writers under exclusive modes
        cur_req = "R9"; rdc = 0; wrc = 0; idle();
        for (int i = 0; i < N; i++) begin wr[i] = 1; ad[i] = AW'(i + 2); wd[i] = DW'(8'h10 + i); end
        do_step();
        read_all("R9");

        // R2: read and write of same word in one step, idle port holds
        cur_req = "R2"; idle();
        rd[0] = 1; ad[0] = 4'd3; wr[1] = 1; ad[1] = 4'd3; wd[1] = 8'hA5;
        do_step();
        idle(); rd[2] = 1; ad[2] = 4'd3;
        do_step();

        // R3: exclusive read collision
        cur_req = "R3"; rdc = 0; idle();
        rd[0] = 1; rd[3] = 1; ad[0] = 4'd3; ad[3] = 4'd3;
        do_step();
        idle(); do_step();

        // R4: exclusive write collision plus an unrelated single write
        cur_req = "R4"; wrc = 0; idle();
        wr[0] = 1; wr[2] = 1; ad[0] = 4'd5; ad[2] = 4'd5; wd[0] = 8'h11; wd[2] = 8'h22;
        wr[1] = 1; ad[1] = 4'd9; wd[1] = 8'h99;
        do_step();
        read_all("R4");

        // R5: agree policy
        cur_req = "R5"; wrc = 1; pol = 2'd0; idle();
        for (int i = 0; i < N; i++) begin wr[i] = 1; ad[i] = 4'd7; wd[i] = 8'h3C; end
        do_step();
        idle(); wr[1] = 1; wr[3] = 1; ad[1] = 4'd7; ad[3] = 4'd7; wd[1] = 8'h01; wd[3] = 8'h02;
        do_step();
        idle(); rd[0] = 1; ad[0] = 4'd7;
        do_step();

        // R6: rotating pointer across several steps
        cur_req = "R6"; pol = 2'd1;
        for (int s = 0; s < 6; s++) begin
            idle();
            for (int i = 0; i < N; i++) begin wr[i] = (s % 2 == 0) || (i != 1); ad[i] = 4'd8; wd[i] = DW'(8'h40 + 16 * s + i); end
            do_step();
            idle(); rd[2] = 1; ad[2] = 4'd8;
            do_step();
        end

        // R7: adding policy with wrap
        cur_req = "R7"; pol = 2'd2; idle();
        for (int i = 0; i < N; i++) begin wr[i] = 1; ad[i] = 4'd12; wd[i] = 8'h70; end
        do_step();
        idle(); rd[1] = 1; ad[1] = 4'd12;
        do_step();

        // R8: rank policy
        cur_req = "R8"; pol = 2'd3; idle();
        for (int i = 1; i < N; i++) begin wr[i] = 1; ad[i] = 4'd13; wd[i] = DW'(8'hB0 + i); end
        do_step();
        idle(); rd[3] = 1; ad[3] = 4'd13;
        do_step();

        // random mix over a narrow address range
        cur_req = "R2";
        for (int s = 0; s < 400; s++) begin
            rdc = 1'($urandom); wrc = 1'($urandom); pol = 2'($urandom);
            for (int i = 0; i < N; i++) begin
                rd[i] = 1'($urandom); wr[i] = 1'($urandom);
                ad[i] = AW'($urandom_range(0, 3)); wd[i] = DW'($urandom);
            end
            do_step();
        end
        read_all("R9");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule